// File: doc/BRIEF.md
# Circular Sample Memory Controller

This block is the digital sequencer for a multi-channel analog sample store made of `DEPTH` cells per channel and used as a ring. During the write phase a column pointer moves forward by one cell on every sample tick and wraps from the top cell back to cell 0, so the store always holds the latest `DEPTH` samples. While writing, a per-channel hit bit is set whenever that channel's discriminator input is high.

A trigger ends the write phase. The controller freezes the pointer, records the stop cell, and captures the channel selection and the cell count. It then streams `(channel, cell)` address pairs, one per clock with a valid strobe. Channels come in ascending order. For each selected channel the cells start at the oldest sample, which is the cell after the stop cell, and run for the programmed count. A one-cycle done pulse ends the readout. The controller then waits in a hold phase until it is re-armed.

The states are ST_WRITE (sampling), ST_PICK (choose the lowest channel still pending), ST_READ (emit cells), ST_DONE (done pulse) and ST_HOLD (idle until re-arm). The transitions are:
- ST_WRITE to ST_PICK on a trigger.
- ST_PICK to ST_READ when a channel is pending, otherwise to ST_DONE.
- ST_READ to ST_PICK after the last cell of a channel.
- ST_DONE to ST_HOLD unconditionally.
- ST_HOLD to ST_WRITE on re-arm.

Top module: `sca_seq_ctrl`

## Requirements
- R1: In the write phase `wr_ptr` steps by one on each clock with `samp_tick` high and wraps from DEPTH-1 to 0. Reset and re-arm both set it to 0.
- R2: A trigger in the write phase ends writing. A `samp_tick` in the same cycle is ignored. `wr_ptr` then stays frozen until re-arm. `busy` is high from the cycle after the trigger through the done cycle.
- R3: Every selected channel is read from cell (stop+1) mod DEPTH, and the cell advances by one modulo DEPTH on each beat. Here stop is the `wr_ptr` value in the trigger cycle.
- R4: The cell count is taken from `cell_cnt` in the trigger cycle and later changes have no effect. Values 1..DEPTH are used as given; 0 or any value above DEPTH means DEPTH.
- R5: Selected channels are read in ascending index order. `mode_sel` 2'b00 selects all channels, and 2'b11 does the same.
- R6: `mode_sel` 2'b01 selects the channels whose hit bit is set. A hit bit is set by `hit_in` high in any write-phase cycle before the trigger cycle.
- R7: `mode_sel` 2'b10 selects exactly the channels whose `chan_mask` bit is 1, taken in the trigger cycle.
- R8: `rd_done` is a single-cycle pulse after the last beat, and `busy` is low in the next cycle. With an empty selection `rd_done` comes with no beats.
- R9: A trigger during readout or hold changes neither the stream nor `wr_ptr`, and does not raise `busy` in hold.
- R10: After reset the block is writing at cell 0 with `busy` and `rd_valid` low. `rearm` in hold clears all hit bits and restarts writing at cell 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| samp_tick | input | 1 | Sample tick, advances write pointer |
| trig_in | input | 1 | Trigger, stops the write phase |
| hit_in | input | NCH | Per-channel discriminator outputs |
| mode_sel | input | 2 | Channel readout mode |
| chan_mask | input | NCH | Explicit channel set for mask mode |
| cell_cnt | input | $clog2(DEPTH)+1 | Cells to read per channel |
| rearm | input | 1 | Restart the write phase from hold |
| writing | output | 1 | High in the write phase |
| wr_ptr | output | $clog2(DEPTH) | Current write cell |
| busy | output | 1 | Readout in progress |
| rd_valid | output | 1 | Address beat valid |
| rd_chan | output | $clog2(NCH) | Channel of the beat |
| rd_cell | output | $clog2(DEPTH) | Cell of the beat |
| rd_done | output | 1 | Readout finished pulse |

## Verification
All four mode codes are swept against cell counts of 1, 2 and 7, plus the full depth, zero and an out-of-range value. The tick counts before the trigger are chosen so that the stop cell falls at 0, mid-ring and the top cell. A stop at the top cell exposes a broken wrap of the readout start, and counts of 0 and above DEPTH show whether clamping happens. Sparse and empty hit and mask patterns separate hit mode from mask mode and from all mode. A hit-mode run with no new hits after re-arm shows whether stale hit bits were cleared. Triggers and ticks injected during readout and hold, and a change of `cell_cnt` right after the trigger, reveal any state that should have been frozen but was not.

// File: rtl/sca_ctrl_pkg.sv
package sca_ctrl_pkg;

    typedef enum logic [2:0] {
        ST_WRITE = 3'd0,
        ST_PICK  = 3'd1,
        ST_READ  = 3'd2,
        ST_DONE  = 3'd3,
        ST_HOLD  = 3'd4
    } phase_e;

    typedef enum logic [1:0] {
        CM_ALL  = 2'b00,
        CM_HIT  = 2'b01,
        CM_MASK = 2'b10,
        CM_ALLB = 2'b11
    } chmode_e;

endpackage

// File: rtl/sca_wr_ring.sv
module sca_wr_ring #(
    parameter int DEPTH = 512,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          adv,
    output logic [AW-1:0] ptr
);

    localparam logic [AW-1:0] TOP = AW'(DEPTH - 1);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr <= '0;
        end else if (clr) begin
            ptr <= '0;
        end else if (adv) begin
            ptr <= (ptr == TOP) ? '0 : ptr + 1'b1;
        end
    end

    // R1
    ring_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && !clr && ptr == TOP) |=> (ptr == '0));

    // R1
    ring_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!adv && !clr) |=> $stable(ptr));

endmodule

// File: rtl/sca_hit_bank.sv
module sca_hit_bank #(
    parameter int NCH = 64
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           clr,
    input  logic           cap,
    input  logic [NCH-1:0] hit_in,
    output logic [NCH-1:0] hit_q
);

    for (genvar g = 0; g < NCH; g++) begin : g_hit
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                hit_q[g] <= 1'b0;
            end else if (clr) begin
                hit_q[g] <= 1'b0;
            end else if (cap && hit_in[g]) begin
                hit_q[g] <= 1'b1;
            end
        end
    end

    // R6
    hit_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cap && !clr) |=> $stable(hit_q));

    // R6
    hit_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr) |=> ((hit_q & $past(hit_q)) == $past(hit_q)));

endmodule

// File: rtl/sca_chan_pick.sv
module sca_chan_pick #(
    parameter int NCH = 64,
    localparam int CW = $clog2(NCH)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] pend,
    output logic           any,
    output logic [CW-1:0]  idx
);

    always_comb begin
        idx = '0;
        for (int i = NCH - 1; i >= 0; i--) begin
            if (pend[i]) idx = CW'(i);
        end
        any = |pend;
    end

    // R5
    pick_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        any |-> pend[idx]);

    // R5
    pick_lowest_chk: assert property (@(posedge clk) disable iff (!rst_n)
        any |-> ((pend & ((NCH'(1) << idx) - NCH'(1))) == '0));

endmodule

// File: rtl/sca_seq_ctrl.sv
module sca_seq_ctrl
    import sca_ctrl_pkg::*;
#(
    parameter int NCH   = 64,
    parameter int DEPTH = 512,
    localparam int CW = $clog2(NCH),
    localparam int AW = $clog2(DEPTH)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           samp_tick,
    input  logic           trig_in,
    input  logic [NCH-1:0] hit_in,
    input  logic [1:0]     mode_sel,
    input  logic [NCH-1:0] chan_mask,
    input  logic [AW:0]    cell_cnt,
    input  logic           rearm,
    output logic           writing,
    output logic [AW-1:0]  wr_ptr,
    output logic           busy,
    output logic           rd_valid,
    output logic [CW-1:0]  rd_chan,
    output logic [AW-1:0]  rd_cell,
    output logic           rd_done
);

    localparam logic [AW:0]   FULL = (AW + 1)'(DEPTH);
    localparam logic [AW-1:0] TOP  = AW'(DEPTH - 1);

    phase_e         state_q, state_d;
    logic [AW-1:0]  stop_q, start_q, cell_q;
    logic [AW:0]    left_q, ncell_q, ncell_in;
    logic [NCH-1:0] sel_q, pend_q, sel_in, hit_q;
    logic [CW-1:0]  chan_q, pick_idx;
    logic           pick_any, ring_adv, phase_clr, in_write;

    function automatic logic [AW-1:0] ring_next(input logic [AW-1:0] x);
        return (x == TOP) ? '0 : x + 1'b1;
    endfunction

    assign in_write  = (state_q == ST_WRITE);
    assign ring_adv  = in_write && samp_tick && !trig_in;
    assign phase_clr = (state_q == ST_HOLD) && rearm;

    sca_wr_ring #(.DEPTH(DEPTH)) ring_i (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (phase_clr),
        .adv  (ring_adv),
        .ptr  (wr_ptr)
    );

    sca_hit_bank #(.NCH(NCH)) hits_i (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (phase_clr),
        .cap   (in_write && !trig_in),
        .hit_in(hit_in),
        .hit_q (hit_q)
    );

    sca_chan_pick #(.NCH(NCH)) pick_i (
        .clk  (clk),
        .rst_n(rst_n),
        .pend (pend_q),
        .any  (pick_any),
        .idx  (pick_idx)
    );

    always_comb begin
        unique case (mode_sel)
            CM_HIT:  sel_in = hit_q;
            CM_MASK: sel_in = chan_mask;
            default: sel_in = '1;
        endcase
        if (cell_cnt == '0 || cell_cnt > FULL) ncell_in = FULL;
        else                                   ncell_in = cell_cnt;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_WRITE: if (trig_in) state_d = ST_PICK;
            ST_PICK:  state_d = pick_any ? ST_READ : ST_DONE;
            ST_READ:  if (left_q == (AW + 1)'(1)) state_d = ST_PICK;
            ST_DONE:  state_d = ST_HOLD;
            ST_HOLD:  if (rearm) state_d = ST_WRITE;
            default:  state_d = ST_WRITE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_WRITE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stop_q  <= '0;
            start_q <= '0;
            sel_q   <= '0;
            pend_q  <= '0;
            ncell_q <= '0;
            chan_q  <= '0;
            cell_q  <= '0;
            left_q  <= '0;
        end else begin
            unique case (state_q)
                ST_WRITE: begin
                    if (trig_in) begin
                        stop_q  <= wr_ptr;
                        start_q <= ring_next(wr_ptr);
                        sel_q   <= sel_in;
                        pend_q  <= sel_in;
                        ncell_q <= ncell_in;
                    end
                end
                ST_PICK: begin
                    if (pick_any) begin
                        chan_q           <= pick_idx;
                        pend_q[pick_idx] <= 1'b0;
                        cell_q           <= start_q;
                        left_q           <= ncell_q;
                    end
                end
                ST_READ: begin
                    cell_q <= ring_next(cell_q);
                    left_q <= left_q - 1'b1;
                end
                ST_HOLD: begin
                    if (rearm) begin
                        sel_q  <= '0;
                        pend_q <= '0;
                    end
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        writing  = in_write;
        busy     = (state_q == ST_PICK) || (state_q == ST_READ) || (state_q == ST_DONE);
        rd_valid = (state_q == ST_READ);
        rd_chan  = chan_q;
        rd_cell  = cell_q;
        rd_done  = (state_q == ST_DONE);
    end

    // R2
    wr_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(wr_ptr));

    // R2
    trig_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (writing && trig_in) |=> (busy && !writing));

    // R3
    first_cell_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && !$past(rd_valid)) |-> (rd_cell == ring_next(stop_q)));

    // R3
    cell_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && $past(rd_valid)) |-> (rd_cell == ring_next($past(rd_cell))));

    // R5
    sel_member_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> sel_q[rd_chan]);

    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_done |=> (!rd_done && !busy));

    // R9
    hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !writing && !rearm) |=> (!busy && $stable(wr_ptr)));

endmodule

// File: tb/sca_seq_ctrl_tb.sv
module sca_seq_ctrl_tb_top;

    localparam int NCH   = 8;
    localparam int DEPTH = 16;
    localparam int CW    = $clog2(NCH);
    localparam int AW    = $clog2(DEPTH);

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           samp_tick = 1'b0;
    logic           trig_in = 1'b0;
    logic [NCH-1:0] hit_in = '0;
    logic [1:0]     mode_sel = 2'b00;
    logic [NCH-1:0] chan_mask = '0;
    logic [AW:0]    cell_cnt = '0;
    logic           rearm = 1'b0;
    logic           writing, busy, rd_valid, rd_done;
    logic [AW-1:0]  wr_ptr, rd_cell;
    logic [CW-1:0]  rd_chan;

    int n_chk = 0;
    int n_bad = 0;

    int exp_ch [NCH*DEPTH];
    int exp_cl [NCH*DEPTH];

    always #2.5 clk = ~clk;

    sca_seq_ctrl #(.NCH(NCH), .DEPTH(DEPTH)) dut_i (
        .clk(clk), .rst_n(rst_n), .samp_tick(samp_tick), .trig_in(trig_in),
        .hit_in(hit_in), .mode_sel(mode_sel), .chan_mask(chan_mask),
        .cell_cnt(cell_cnt), .rearm(rearm), .writing(writing), .wr_ptr(wr_ptr),
        .busy(busy), .rd_valid(rd_valid), .rd_chan(rd_chan), .rd_cell(rd_cell),
        .rd_done(rd_done)
    );

    task automatic check(input bit ok, input string req, input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    task automatic run_case(input int nticks, input logic [NCH-1:0] hits, input int mode,
                            input logic [NCH-1:0] mask, input int cnt, input bit poke);
        logic [NCH-1:0] sel;
        int stop, start, ncells, nexp, beats, guard;
        bit seen_done;
        @(negedge clk); rearm = 1'b1;
        @(negedge clk); rearm = 1'b0;
        check(wr_ptr == 0 && writing, "R10 rearm ptr", int'(wr_ptr), 0);
        hit_in = hits;
        @(negedge clk); hit_in = '0;
        for (int i = 0; i < nticks; i++) begin
            samp_tick = 1'b1;
            @(negedge clk);
        end
        samp_tick = 1'b0;
        stop = nticks % DEPTH;
        check(int'(wr_ptr) == stop, "R1 pointer wrap", int'(wr_ptr), stop);
        mode_sel = 2'(mode); chan_mask = mask; cell_cnt = (AW+1)'(cnt);
        trig_in = 1'b1; samp_tick = 1'b1;
        @(negedge clk);
        trig_in = 1'b0; samp_tick = 1'b0;
        cell_cnt = (AW+1)'(3);
        check(busy && int'(wr_ptr) == stop, "R2 trigger stop", int'(wr_ptr), stop);
        case (mode)
            1:       sel = hits;
            2:       sel = mask;
            default: sel = '1;
        endcase
        ncells = (cnt == 0 || cnt > DEPTH) ? DEPTH : cnt;
        start = (stop + 1) % DEPTH;
        nexp = 0;
        for (int c = 0; c < NCH; c++) begin
            if (sel[c]) begin
                for (int k = 0; k < ncells; k++) begin
                    exp_ch[nexp] = c;
                    exp_cl[nexp] = (start + k) % DEPTH;
                    nexp++;
                end
            end
        end
        beats = 0; guard = 0; seen_done = 1'b0;
        while (!seen_done && guard < 4000) begin
            if (rd_valid) begin
                if (beats < nexp) begin
                    check(int'(rd_chan) == exp_ch[beats], "R5/R6/R7 channel", int'(rd_chan), exp_ch[beats]);
                    check(int'(rd_cell) == exp_cl[beats], "R3/R4 cell", int'(rd_cell), exp_cl[beats]);
                end else begin
                    check(1'b0, "R8 extra beat", beats, nexp);
                end
                beats++;
            end
            if (rd_done) seen_done = 1'b1;
            trig_in   = poke && (guard == 2);
            samp_tick = poke && (guard == 2);
            guard++;
            @(negedge clk);
            trig_in = 1'b0; samp_tick = 1'b0;
        end
        check(seen_done, "R8 done seen", int'(seen_done), 1);
        check(beats == nexp, "R8 beat count", beats, nexp);
        check(!busy && !rd_done, "R8 busy drop", int'(busy), 0);
        check(int'(wr_ptr) == stop, "R9 ptr frozen", int'(wr_ptr), stop);
        trig_in = 1'b1; samp_tick = 1'b1;
        @(negedge clk);
        trig_in = 1'b0; samp_tick = 1'b0;
        @(negedge clk);
        check(!busy && !writing && int'(wr_ptr) == stop, "R9 hold trigger", int'(busy), 0);
    endtask

    initial begin
        #(5.0 * 190000);
        check(1'b0, "watchdog", 0, 1);
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        int cnts [6] = '{1, 2, 7, 16, 0, 20};
        int tks  [3] = '{0, 15, 37};
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10 reset state
        check(writing && !busy && !rd_valid && !rd_done && wr_ptr == 0, "R10 reset", int'(wr_ptr), 0);
        for (int m = 0; m < 4; m++) begin
            for (int c = 0; c < 6; c++) begin
                run_case(tks[(m + c) % 3], 8'b1010_0110, m, 8'b0100_1001, cnts[c], (c % 2) == 1);
            end
        end
        // R6 empty hit set after rearm: stale hits must be gone (R10)
        run_case(5, 8'h00, 1, 8'hFF, 4, 1'b0);
        // R7 empty mask
        run_case(9, 8'hFF, 2, 8'h00, 4, 1'b0);
        // R7 single top channel, R3 stop at top cell
        run_case(DEPTH - 1, 8'h00, 2, 8'h80, 16, 1'b1);
        // R6 single low channel
        run_case(3, 8'h01, 1, 8'h00, 2, 1'b0);
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule